// File: doc/BRIEF.md
# Interrupt Acceptance Controller

This block sits next to a small processor core and decides, cycle by cycle, whether a reset request, a non-maskable interrupt (NMI) or one of several maskable interrupt sources takes control of the core. Each request line is edge-captured into a sticky pending bit. Every cycle the block checks the pending bits against the blocking flags in the status word (PSW). When it accepts a request, it saves the current program counter and PSW into the save pair for that class, rewrites the PSW flags and the cause register, and sends a one-cycle redirect strobe with the handler address.

The core owns the PSW between acceptances. It drives a new PSW value with a write strobe, and a return-from-handler sequence uses this path to clear the blocking flags again. An NMI that arrives while an earlier one is still being handled is not counted. It folds into a single pending request that is retried every cycle. Maskable requests wait in the same way until both blocking flags are clear.

Top module: `irq_accept_top`

## Requirements
- R1: After the chip reset input `rstN` is released, the PSW reads 0x20, the cause register and all four save registers read 0, and the redirect strobe is low.
- R2: While `resetReq` is high at a clock edge, the next cycle shows PSW 0x20, cause 0 and a redirect to address 0. Every pending NMI and maskable request is discarded and none of them is accepted in that cycle.
- R3: The PSW flag bits are ID = bit 5, EP = bit 6 and NP = bit 7. A pending NMI is accepted when NP is clear. On acceptance the NMI save PC gets `curPc`, the NMI save PSW gets the old PSW, NP and ID are set, EP is cleared, the redirect goes to 0x10, and the cause register's upper 16 bits become 0x0010 while its lower 16 bits are kept.
- R4: An NMI that rises while NP is set is held as one pending request. Any number of further NMI edges merge into it, and it is accepted exactly once, in the cycle after the PSW shows NP clear.
- R5: A pending maskable request is not accepted while NP or ID is set. It stays pending until both flags are clear.
- R6: On maskable acceptance the maskable save PC gets `curPc`, the maskable save PSW gets the old PSW, ID is set, EP is cleared, the lower 16 bits of the cause register become the source code, and the upper 16 bits are kept.
- R7: Source i (bit i of `irqReq`) vectors to 0x80 + 0x10*i, so sources 0 to 5 go to 0x80, 0x90, 0xA0, 0xB0, 0xC0 and 0xD0. The cause code of each source equals its vector.
- R8: Priority is reset request first, then NMI, then maskable sources. Among pending maskable sources the lowest index wins, and the others stay pending.
- R9: Only a rising edge of a request line sets its pending bit. A line held high produces one acceptance, and a short pulse stays pending after the line drops.
- R10: The redirect strobe is high for exactly one cycle per acceptance. A core PSW write loads `pswIn` on the next cycle when nothing is accepted, and it is discarded when an acceptance happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous chip reset, active low |
| resetReq | input | 1 | Functional reset request, level sampled |
| nmiReq | input | 1 | Non-maskable interrupt request line |
| irqReq | input | NUM_SRC | Maskable request lines, bit 0 has highest priority |
| curPc | input | XLEN | Program counter of the core in the current cycle |
| pswIn | input | XLEN | PSW value written by the core |
| pswWe | input | 1 | PSW write strobe from the core |
| pswOut | output | XLEN | Current PSW |
| causeReg | output | XLEN | Cause register: NMI code in upper half, maskable code in lower half |
| nmiSavePc | output | XLEN | PC saved on NMI acceptance |
| nmiSavePsw | output | XLEN | PSW saved on NMI acceptance |
| irqSavePc | output | XLEN | PC saved on maskable acceptance |
| irqSavePsw | output | XLEN | PSW saved on maskable acceptance |
| redirect | output | 1 | One-cycle strobe requesting a jump |
| redirectPc | output | XLEN | Target address of the redirect |

## Verification
A pending bit that is lost or stuck shows up at the ports within one or two cycles of the PSW flags clearing. It appears as a redirect that is missing, doubled, or pointing at the wrong vector. A wrong blocking decision or priority shows as a redirect in a cycle where the model expects none, or as a different handler address. A bad save or flag update is seen in the save registers, the PSW and the cause halves in the cycle after acceptance. The bench compares every output against a reference model on every cycle, so a divergence is reported in the first cycle it reaches a port.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

  localparam int PSW_ID_BIT = 5;
  localparam int PSW_EP_BIT = 6;
  localparam int PSW_NP_BIT = 7;

  localparam int IDX_W = 4;

  typedef struct packed {
    logic              rstTake;
    logic              nmiTake;
    logic              maskTake;
    logic [IDX_W-1:0]  srcIdx;
  } ctlStrobes_t;

endpackage

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
  import irq_accept_pkg::*;
#(
  parameter int NUM_SRC = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               resetReq,
  input  logic               nmiReq,
  input  logic [NUM_SRC-1:0] irqReq,
  input  logic               pswNp,
  input  logic               pswId,
  output ctlStrobes_t        strobes
);

  logic               nmiPrev;
  logic               nmiPend;
  logic [NUM_SRC-1:0] irqPrev;
  logic [NUM_SRC-1:0] irqPend;
  logic [NUM_SRC-1:0] irqRise;
  logic [NUM_SRC-1:0] grantVec;
  logic [NUM_SRC-1:0] takeVec;
  logic [NUM_SRC:0]   seenBelow;
  logic               nmiRise;
  logic               nmiTake;
  logic               maskTake;
  logic [IDX_W-1:0]   srcIdx;

  assign irqRise = irqReq & ~irqPrev;
  assign nmiRise = nmiReq & ~nmiPrev;

  // Lowest-index-first priority chain
  assign seenBelow[0] = 1'b0;
  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : gPrio
    assign grantVec[gi]     = irqPend[gi] & ~seenBelow[gi];
    assign seenBelow[gi+1]  = seenBelow[gi] | irqPend[gi];
  end

  assign nmiTake  = !resetReq && nmiPend && !pswNp;
  assign maskTake = !resetReq && !nmiTake && (|irqPend) && !pswNp && !pswId;
  assign takeVec  = maskTake ? grantVec : '0;

  always_comb begin
    srcIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (grantVec[i]) srcIdx = IDX_W'(i);
    end
  end

  always_comb begin
    strobes.rstTake  = resetReq;
    strobes.nmiTake  = nmiTake;
    strobes.maskTake = maskTake;
    strobes.srcIdx   = srcIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nmiPrev <= 1'b0;
      irqPrev <= '0;
      nmiPend <= 1'b0;
      irqPend <= '0;
    end else begin
      nmiPrev <= nmiReq;
      irqPrev <= irqReq;
      if (resetReq) begin
        nmiPend <= 1'b0;
        irqPend <= '0;
      end else begin
        nmiPend <= (nmiPend & ~nmiTake) | nmiRise;
        irqPend <= (irqPend & ~takeVec) | irqRise;
      end
    end
  end

  AST_ONE_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({resetReq, nmiTake, maskTake})) else $error("AST_ONE_TAKE"); // R8
  AST_NMI_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    nmiTake |-> !pswNp) else $error("AST_NMI_BLOCKED"); // R3
  AST_MASK_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    maskTake |-> (!pswNp && !pswId && !nmiPend)) else $error("AST_MASK_BLOCKED"); // R5
  AST_NMI_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (nmiPend && pswNp && !resetReq) |=> nmiPend) else $error("AST_NMI_HELD"); // R4

  for (genvar gk = 0; gk < NUM_SRC; gk++) begin : gKeep
    AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!rstN)
      (irqPend[gk] && !takeVec[gk] && !resetReq) |=> irqPend[gk])
      else $error("AST_PEND_KEPT"); // R9
  end

endmodule

// File: rtl/irq_accept_datapath.sv
module irq_accept_datapath
  import irq_accept_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter int unsigned VEC_BASE  = 32'h80,
  parameter int unsigned VEC_STEP  = 32'h10,
  parameter int unsigned NMI_VEC   = 32'h10,
  parameter int unsigned NMI_CODE  = 32'h10,
  parameter int unsigned RESET_PSW = 32'h20
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctlStrobes_t     strobes,
  input  logic [XLEN-1:0] curPc,
  input  logic [XLEN-1:0] pswIn,
  input  logic            pswWe,
  output logic [XLEN-1:0] pswOut,
  output logic [XLEN-1:0] causeReg,
  output logic [XLEN-1:0] nmiSavePc,
  output logic [XLEN-1:0] nmiSavePsw,
  output logic [XLEN-1:0] irqSavePc,
  output logic [XLEN-1:0] irqSavePsw,
  output logic            redirect,
  output logic [XLEN-1:0] redirectPc
);

  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] maskVec;
  logic [XLEN-1:0] pswNmi;
  logic [XLEN-1:0] pswMask;
  logic            anyTake;

  assign maskVec = XLEN'(VEC_BASE) + XLEN'(strobes.srcIdx) * XLEN'(VEC_STEP);
  assign anyTake = strobes.rstTake | strobes.nmiTake | strobes.maskTake;

  always_comb begin
    pswNmi = pswOut;
    pswNmi[PSW_NP_BIT] = 1'b1;
    pswNmi[PSW_ID_BIT] = 1'b1;
    pswNmi[PSW_EP_BIT] = 1'b0;
    pswMask = pswOut;
    pswMask[PSW_ID_BIT] = 1'b1;
    pswMask[PSW_EP_BIT] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pswOut     <= XLEN'(RESET_PSW);
      causeReg   <= '0;
      nmiSavePc  <= '0;
      nmiSavePsw <= '0;
      irqSavePc  <= '0;
      irqSavePsw <= '0;
      redirect   <= 1'b0;
      redirectPc <= '0;
    end else begin
      redirect <= anyTake;
      if (strobes.rstTake) begin
        pswOut     <= XLEN'(RESET_PSW);
        causeReg   <= '0;
        redirectPc <= '0;
      end else if (strobes.nmiTake) begin
        nmiSavePc  <= curPc;
        nmiSavePsw <= pswOut;
        pswOut     <= pswNmi;
        causeReg   <= {HALF'(NMI_CODE), causeReg[HALF-1:0]};
        redirectPc <= XLEN'(NMI_VEC);
      end else if (strobes.maskTake) begin
        irqSavePc  <= curPc;
        irqSavePsw <= pswOut;
        pswOut     <= pswMask;
        causeReg   <= {causeReg[XLEN-1:HALF], maskVec[HALF-1:0]};
        redirectPc <= maskVec;
      end else if (pswWe) begin
        pswOut <= pswIn;
      end
    end
  end

  AST_NMI_SAVE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.nmiTake |=> (nmiSavePc == $past(curPc) && pswOut[PSW_NP_BIT]
                         && pswOut[PSW_ID_BIT] && !pswOut[PSW_EP_BIT]))
    else $error("AST_NMI_SAVE"); // R3
  AST_MASK_CODE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.maskTake |=> (causeReg[HALF-1:0] == redirectPc[HALF-1:0]
                          && irqSavePc == $past(curPc)))
    else $error("AST_MASK_CODE"); // R7
  AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rstTake |=> (causeReg == '0 && redirect && redirectPc == '0))
    else $error("AST_RESET_WINS"); // R2
  AST_PULSE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    !anyTake |=> !redirect) else $error("AST_PULSE_ONLY"); // R10
  AST_PSW_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (pswWe && !anyTake) |=> pswOut == $past(pswIn)) else $error("AST_PSW_WRITE"); // R10

endmodule

// File: rtl/irq_accept_top.sv
module irq_accept_top
  import irq_accept_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter int          NUM_SRC   = 6,
  parameter int unsigned VEC_BASE  = 32'h80,
  parameter int unsigned VEC_STEP  = 32'h10,
  parameter int unsigned NMI_VEC   = 32'h10,
  parameter int unsigned NMI_CODE  = 32'h10,
  parameter int unsigned RESET_PSW = 32'h20
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               resetReq,
  input  logic               nmiReq,
  input  logic [NUM_SRC-1:0] irqReq,
  input  logic [XLEN-1:0]    curPc,
  input  logic [XLEN-1:0]    pswIn,
  input  logic               pswWe,
  output logic [XLEN-1:0]    pswOut,
  output logic [XLEN-1:0]    causeReg,
  output logic [XLEN-1:0]    nmiSavePc,
  output logic [XLEN-1:0]    nmiSavePsw,
  output logic [XLEN-1:0]    irqSavePc,
  output logic [XLEN-1:0]    irqSavePsw,
  output logic               redirect,
  output logic [XLEN-1:0]    redirectPc
);

  ctlStrobes_t strobes;

  irq_accept_ctrl #(.NUM_SRC(NUM_SRC)) uCtrl (
    .clk(clk), .rstN(rstN), .resetReq(resetReq), .nmiReq(nmiReq),
    .irqReq(irqReq), .pswNp(pswOut[PSW_NP_BIT]), .pswId(pswOut[PSW_ID_BIT]),
    .strobes(strobes)
  );

  irq_accept_datapath #(
    .XLEN(XLEN), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP),
    .NMI_VEC(NMI_VEC), .NMI_CODE(NMI_CODE), .RESET_PSW(RESET_PSW)
  ) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .curPc(curPc),
    .pswIn(pswIn), .pswWe(pswWe), .pswOut(pswOut), .causeReg(causeReg),
    .nmiSavePc(nmiSavePc), .nmiSavePsw(nmiSavePsw), .irqSavePc(irqSavePc),
    .irqSavePsw(irqSavePsw), .redirect(redirect), .redirectPc(redirectPc)
  );

endmodule

// File: tb/tb_irq_accept_top.sv
module tb_irq_accept_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        resetReq = 1'b0;
  logic        nmiReq = 1'b0;
  logic [5:0]  irqReq = '0;
  logic [31:0] curPc = '0;
  logic [31:0] pswIn = '0;
  logic        pswWe = 1'b0;
  logic [31:0] pswOut, causeReg, nmiSavePc, nmiSavePsw, irqSavePc, irqSavePsw, redirectPc;
  logic        redirect;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  // Reference model state
  logic [31:0] mPsw, mCause, mFepc, mFepsw, mEipc, mEipsw, mRedirPc;
  logic        mRedir, mNmiPend, mNmiPrev;
  logic [5:0]  mPend, mPrev;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_accept_top dut (
    .clk(clk), .rstN(rstN), .resetReq(resetReq), .nmiReq(nmiReq), .irqReq(irqReq),
    .curPc(curPc), .pswIn(pswIn), .pswWe(pswWe), .pswOut(pswOut), .causeReg(causeReg),
    .nmiSavePc(nmiSavePc), .nmiSavePsw(nmiSavePsw), .irqSavePc(irqSavePc),
    .irqSavePsw(irqSavePsw), .redirect(redirect), .redirectPc(redirectPc)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] vecOf(int idx);
    return 32'h80 + 32'(idx) * 32'h10;
  endfunction

  task automatic modelReset();
    mPsw = 32'h20; mCause = '0; mFepc = '0; mFepsw = '0; mEipc = '0; mEipsw = '0;
    mRedir = 0; mRedirPc = '0; mNmiPend = 0; mNmiPrev = 0; mPend = '0; mPrev = '0;
  endtask

  task automatic modelEdge();
    logic [5:0] rise;
    logic nRise, nTake, kTake;
    int idx;
    rise  = irqReq & ~mPrev;
    nRise = nmiReq & ~mNmiPrev;
    nTake = !resetReq && mNmiPend && !mPsw[7];
    kTake = !resetReq && !nTake && (mPend != 0) && !mPsw[7] && !mPsw[5];
    idx = 0;
    for (int i = 5; i >= 0; i--) if (mPend[i]) idx = i;
    mRedir = 0;
    if (resetReq) begin
      mPsw = 32'h20; mCause = '0; mRedir = 1; mRedirPc = '0;
      mPend = '0; mNmiPend = 0;
    end else begin
      if (nTake) begin
        mFepc = curPc; mFepsw = mPsw;
        mPsw = (mPsw | 32'hA0) & ~32'h40;
        mCause = {16'h0010, mCause[15:0]};
        mRedir = 1; mRedirPc = 32'h10; mNmiPend = 0;
      end else if (kTake) begin
        mEipc = curPc; mEipsw = mPsw;
        mPsw = (mPsw | 32'h20) & ~32'h40;
        mCause = {mCause[31:16], vecOf(idx)[15:0]};
        mRedir = 1; mRedirPc = vecOf(idx); mPend[idx] = 0;
      end else if (pswWe) begin
        mPsw = pswIn;
      end
      mPend = mPend | rise;
      mNmiPend = mNmiPend | nRise;
    end
    mPrev = irqReq; mNmiPrev = nmiReq;
  endtask

  task automatic compareAll();
    check("R10 redirect", {31'd0, redirect}, {31'd0, mRedir});
    if (mRedir) check("R7 redirectPc", redirectPc, mRedirPc);
    check("R6 psw", pswOut, mPsw);
    check("R3 cause", causeReg, mCause);
    check("R3 nmiSavePc", nmiSavePc, mFepc);
    check("R3 nmiSavePsw", nmiSavePsw, mFepsw);
    check("R6 irqSavePc", irqSavePc, mEipc);
    check("R6 irqSavePsw", irqSavePsw, mEipsw);
  endtask

  // Inputs are driven while clk is low; one edge is taken, outputs sampled at negedge.
  task automatic step();
    modelEdge();
    @(posedge clk);
    @(negedge clk);
    compareAll();
    resetReq = 0; nmiReq = 0; pswWe = 0;
  endtask

  task automatic writePsw(logic [31:0] v);
    pswWe = 1; pswIn = v; step();
  endtask

  initial begin
    int redirCount;
    void'($urandom(32'd4242));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 psw", pswOut, 32'h20);
    check("R1 cause", causeReg, 32'h0);
    check("R1 redirect", {31'd0, redirect}, 32'h0);
    check("R1 saves", nmiSavePc | irqSavePc | nmiSavePsw | irqSavePsw, 32'h0);

    // R3 NMI acceptance
    curPc = 32'h100; nmiReq = 1; step();
    step();
    check("R3 redirect", {31'd0, redirect}, 32'h1);
    check("R3 vector", redirectPc, 32'h10);
    check("R3 fepc", nmiSavePc, 32'h100);
    check("R3 psw", pswOut, 32'hA0);
    check("R3 cause", causeReg, 32'h0010_0000);
    step();
    check("R10 single pulse", {31'd0, redirect}, 32'h0);

    // R4 NMIs while NP set merge into one
    nmiReq = 1; step(); step(); nmiReq = 1; step(); step();
    check("R4 blocked", {31'd0, redirect}, 32'h0);
    writePsw(32'h0);
    redirCount = 0;
    for (int k = 0; k < 4; k++) begin step(); redirCount += redirect; end
    check("R4 merged count", 32'(redirCount), 32'd1);

    // R5 maskable blocked by NP, then by ID
    irqReq = 6'b001010; step(); irqReq = 0; step(); step();
    check("R5 blocked NP", {31'd0, redirect}, 32'h0);
    writePsw(32'h20); step();
    check("R5 blocked ID", {31'd0, redirect}, 32'h0);
    // R8 lowest index first; R10 PSW write overridden by acceptance
    writePsw(32'h0);
    writePsw(32'h0);
    check("R8 lowest first", redirectPc, 32'h90);
    check("R10 write overridden", pswOut, 32'h20);
    check("R6 cause keeps upper", causeReg, 32'h0010_0090);
    writePsw(32'h0); step();
    check("R7 source3 vector", redirectPc, 32'hB0);

    // R8 NMI beats maskable
    nmiReq = 1; irqReq = 6'b000001; writePsw(32'h0); irqReq = 0; step();
    check("R8 nmi first", redirectPc, 32'h10);

    // R2 reset request discards pending
    resetReq = 1; step();
    check("R2 vector", redirectPc, 32'h0);
    check("R2 cause", causeReg, 32'h0);
    writePsw(32'h0);
    redirCount = 0;
    for (int k = 0; k < 3; k++) begin step(); redirCount += redirect; end
    check("R2 pending dropped", 32'(redirCount), 32'd0);

    // R9 level held gives one acceptance
    irqReq = 6'b100000;
    redirCount = 0;
    for (int k = 0; k < 8; k++) begin pswWe = 1; pswIn = 32'h0; step(); redirCount += redirect; end
    check("R9 level once", 32'(redirCount), 32'd1);
    irqReq = 0; step();

    // Constrained random phase
    for (int n = 0; n < 3000; n++) begin
      resetReq = ($urandom % 97) == 0;
      nmiReq   = ($urandom % 7) == 0;
      for (int b = 0; b < 6; b++) irqReq[b] = ($urandom % 5) == 0;
      curPc    = $urandom & 32'hFFFF_FFFC;
      pswWe    = ($urandom % 3) == 0;
      pswIn    = $urandom;
      if ($urandom % 2) pswIn[7:5] = 3'b000;
      step();
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule